// File: doc/BRIEF.md
# Multi-cycle 8-bit CPU sequencer

This block is the control core of a small 8-bit machine. It owns the program counter, the stack pointer, four 8-bit general registers and a 4-bit flag register. It walks each instruction through a fixed series of states: it fetches a 16-bit instruction word one byte per cycle from a byte-wide synchronous memory port, fetches a second address word for the memory and control-flow opcodes, then executes. Arithmetic and logic are done by an external combinational ALU. The sequencer presents the opcode and both source operands to that ALU and takes back the result and four flags.

Memory has a 256-byte address space, and a read issued in one cycle returns its data in the next. LOAD, STORE, JMP, conditional jump and CALL are always four bytes long. Their trailing address word is sent high byte first, and only its low byte selects a location. The other opcodes are two bytes long. A HALT opcode parks the sequencer for good, and it stays parked until the next reset.

Top module: `byte_cpu_seq`

## Requirements
- R1: After reset the PC is 0 and the stack pointer is 0xFF. In the first cycle after reset is released, the block reads address 0 (`mem_re`=1, `mem_addr`=0), with `mem_we`=0 and `halted`=0.
- R2: An instruction word has opcode in bits 15..12, rd in 11..10, rs in 9..8 and an 8-bit immediate in 7..0, stored high byte first. Opcodes 0xA–0xE take a following address word, high byte first, of which only the low byte is used; these instructions are 4 bytes long and the others are 2.
- R3: Opcodes 0x0–0x8 place the opcode on `alu_op`, R[rd] on `alu_a` and R[rs] on `alu_b`. They write `alu_y` into R[rd] and latch `alu_flags` as flags {Z,N,C,V} (bits 3..0). The PC advances by 2.
- R4: Opcode 0x9 (compare) latches the ALU flags and leaves R[rd] unchanged.
- R5: Opcode 0xA loads the addressed byte into R[rd]. Opcode 0xB writes R[rs] to the addressed byte.
- R6: Opcode 0xD jumps when the condition chosen by imm[2:0] holds: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear. Otherwise the PC advances by 4.
- R7: Opcode 0xC loads the address into the PC.
- R8: Opcode 0xE decrements SP by one and writes the return address (instruction start + 4) at the new SP. It then jumps to the address. SP changes in no other way.
- R9: Opcode 0xF raises `halted`. From then on, `halted` stays high and no memory read or write is issued.
- R10: `mem_re` and `mem_we` are never asserted together, and read data is taken one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory byte address |
| mem_re | output | 1 | Memory read enable; data returns next cycle |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| alu_op | output | 4 | Opcode presented to the ALU |
| alu_a | output | 8 | First ALU operand, R[rd] |
| alu_b | output | 8 | Second ALU operand, R[rs] |
| alu_y | input | 8 | ALU result |
| alu_flags | input | 4 | ALU flags {Z,N,C,V} |
| halted | output | 1 | High once HALT has executed |

## Verification
Registers and flags are not visible at the ports, so test programs move every internal value out through a store. A register that is indexed or written wrongly shows up as a wrong byte at the store's target address. A wrong PC step shows up at the next fetch address, and in the programs it leads either to a missing marker or to a HALT that never comes. A bad flag or condition decode shows up at the next conditional jump, which picks which marker constant gets stored. A wrong SP shows up in the location of the return bytes pushed by two nested calls. All of these appear within one or two instructions of the fault.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int OP_W   = 4;
    localparam int NREG   = 4;
    localparam int RIDX_W = $clog2(NREG);
    localparam int FLAG_W = 4;
    localparam int COND_W = 3;

    // flag bit positions inside the flag register: {Z,N,C,V}
    localparam int FLG_Z = 3;
    localparam int FLG_N = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    localparam logic [OP_W-1:0] OPC_CMP   = 4'h9;
    localparam logic [OP_W-1:0] OPC_LOAD  = 4'hA;
    localparam logic [OP_W-1:0] OPC_STORE = 4'hB;
    localparam logic [OP_W-1:0] OPC_JMP   = 4'hC;
    localparam logic [OP_W-1:0] OPC_JCC   = 4'hD;
    localparam logic [OP_W-1:0] OPC_CALL  = 4'hE;
    localparam logic [OP_W-1:0] OPC_HALT  = 4'hF;

    localparam int SHORT_LEN = 2;
    localparam int LONG_LEN  = 4;

    typedef enum logic [2:0] {
        S_FETCH_HI,
        S_FETCH_LO,
        S_ADDR_HI,
        S_ADDR_LO,
        S_EXEC,
        S_MEM,
        S_HALTED
    } seq_state_e;

    function automatic logic has_addr_word(input logic [OP_W-1:0] op);
        return (op >= OPC_LOAD) && (op <= OPC_CALL);
    endfunction

endpackage

// File: rtl/cpu_seq_decode.sv
module cpu_seq_decode
    import cpu_seq_pkg::*;
(
    input  logic [DATA_W-1:0] hi_byte,
    output logic [OP_W-1:0]   op,
    output logic [RIDX_W-1:0] rd,
    output logic [RIDX_W-1:0] rs,
    output logic              is_alu,
    output logic              writes_rd
);
    always_comb begin
        op        = hi_byte[DATA_W-1 -: OP_W];
        rd        = hi_byte[2*RIDX_W-1 -: RIDX_W];
        rs        = hi_byte[RIDX_W-1:0];
        is_alu    = (op <= OPC_CMP);
        writes_rd = is_alu && (op != OPC_CMP);
    end
endmodule

// File: rtl/cpu_seq_cond.sv
module cpu_seq_cond
    import cpu_seq_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [COND_W-1:0] sel,
    output logic              take
);
    logic [3:0] pick;

    always_comb begin
        // sel[2:1]: 0 Z, 1 C, 2 N, 3 V ; sel[0] inverts
        pick[0] = flags[FLG_Z];
        pick[1] = flags[FLG_C];
        pick[2] = flags[FLG_N];
        pick[3] = flags[FLG_V];
        take    = pick[sel[2:1]] ^ sel[0];
    end
endmodule

// File: rtl/cpu_seq_regs.sv
module cpu_seq_regs #(
    parameter int N  = 4,
    parameter int W  = 8,
    localparam int IW = $clog2(N)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    output logic [W-1:0]  qa,
    output logic [W-1:0]  qb
);
    logic [N-1:0][W-1:0] regs_d;
    logic [N-1:0][W-1:0] regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < N; i++) begin
            if (we && (waddr == IW'(i))) begin
                regs_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign qa = regs_q[ra];
    assign qb = regs_q[rb];

    // R3: a register changes only in a cycle in which the write port targets it
    for (genvar g = 0; g < N; g++) begin : g_chk
        p_reg_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (waddr == IW'(g))) |=> $stable(regs_q[g]));
    end
endmodule

// File: rtl/byte_cpu_seq.sv
module byte_cpu_seq
    import cpu_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SP_RESET = '1,
    parameter logic [ADDR_W-1:0] PC_RESET = '0
)(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [OP_W-1:0]   alu_op,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b,
    input  logic [DATA_W-1:0] alu_y,
    input  logic [FLAG_W-1:0] alu_flags,
    output logic              halted
);
    typedef struct packed {
        seq_state_e          st;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   sp;
        logic [DATA_W-1:0]   ir_hi;
        logic [COND_W-1:0]   csel;
        logic [FLAG_W-1:0]   flags;
        logic                halt;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        st: S_FETCH_HI, pc: PC_RESET, sp: SP_RESET,
        ir_hi: '0, csel: '0, flags: '0, halt: 1'b0
    };

    seq_t r_d;
    seq_t r_q;

    logic [OP_W-1:0]   dec_op;
    logic [RIDX_W-1:0] dec_rd;
    logic [RIDX_W-1:0] dec_rs;
    logic              dec_is_alu;
    logic              dec_wr;
    logic              cond_take;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] rf_qa;
    logic [DATA_W-1:0] rf_qb;

    cpu_seq_decode u_dec (
        .hi_byte   (r_q.ir_hi),
        .op        (dec_op),
        .rd        (dec_rd),
        .rs        (dec_rs),
        .is_alu    (dec_is_alu),
        .writes_rd (dec_wr)
    );

    cpu_seq_cond u_cond (
        .flags (r_q.flags),
        .sel   (r_q.csel),
        .take  (cond_take)
    );

    cpu_seq_regs #(.N(NREG), .W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra    (dec_rd),
        .rb    (dec_rs),
        .qa    (rf_qa),
        .qb    (rf_qb)
    );

    assign alu_op = dec_op;
    assign alu_a  = rf_qa;
    assign alu_b  = rf_qb;
    assign halted = r_q.halt;

    always_comb begin
        r_d       = r_q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.pc;
        mem_wdata = '0;
        rf_we     = 1'b0;
        rf_waddr  = dec_rd;
        rf_wdata  = alu_y;

        unique case (r_q.st)
            S_FETCH_HI: begin
                mem_re  = 1'b1;
                r_d.st  = S_FETCH_LO;
            end
            S_FETCH_LO: begin
                mem_re    = 1'b1;
                mem_addr  = r_q.pc + ADDR_W'(1);
                r_d.ir_hi = mem_rdata;
                r_d.st    = has_addr_word(mem_rdata[DATA_W-1 -: OP_W]) ? S_ADDR_HI : S_EXEC;
            end
            S_ADDR_HI: begin
                // read data here is the immediate byte of the instruction
                mem_re   = 1'b1;
                mem_addr = r_q.pc + ADDR_W'(2);
                r_d.csel = mem_rdata[COND_W-1:0];
                r_d.st   = S_ADDR_LO;
            end
            S_ADDR_LO: begin
                // read data here is the address high byte, which is unused
                mem_re   = 1'b1;
                mem_addr = r_q.pc + ADDR_W'(3);
                r_d.st   = S_EXEC;
            end
            S_EXEC: begin
                r_d.st = S_FETCH_HI;
                if (dec_is_alu) begin
                    rf_we     = dec_wr;
                    r_d.flags = alu_flags;
                    r_d.pc    = r_q.pc + ADDR_W'(SHORT_LEN);
                end else begin
                    unique case (dec_op)
                        OPC_LOAD: begin
                            mem_re   = 1'b1;
                            mem_addr = mem_rdata[ADDR_W-1:0];
                            r_d.pc   = r_q.pc + ADDR_W'(LONG_LEN);
                            r_d.st   = S_MEM;
                        end
                        OPC_STORE: begin
                            mem_we    = 1'b1;
                            mem_addr  = mem_rdata[ADDR_W-1:0];
                            mem_wdata = rf_qb;
                            r_d.pc    = r_q.pc + ADDR_W'(LONG_LEN);
                        end
                        OPC_JMP: begin
                            r_d.pc = mem_rdata[ADDR_W-1:0];
                        end
                        OPC_JCC: begin
                            r_d.pc = cond_take ? mem_rdata[ADDR_W-1:0]
                                               : r_q.pc + ADDR_W'(LONG_LEN);
                        end
                        OPC_CALL: begin
                            r_d.sp    = r_q.sp - ADDR_W'(1);
                            mem_we    = 1'b1;
                            mem_addr  = r_q.sp - ADDR_W'(1);
                            mem_wdata = DATA_W'(r_q.pc + ADDR_W'(LONG_LEN));
                            r_d.pc    = mem_rdata[ADDR_W-1:0];
                        end
                        default: begin
                            r_d.halt = 1'b1;
                            r_d.st   = S_HALTED;
                        end
                    endcase
                end
            end
            S_MEM: begin
                rf_we    = 1'b1;
                rf_wdata = mem_rdata;
                r_d.st   = S_FETCH_HI;
            end
            default: begin
                r_d.halt = 1'b1;
                r_d.st   = S_HALTED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SEQ_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    // R9: once halted, the memory port stays idle
    p_quiet_after_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.halt |-> (!mem_re && !mem_we));

    // R9: halted never drops before reset
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.halt |=> r_q.halt);

    // R8: the stack pointer only ever steps down by one
    p_sp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sp != $past(r_q.sp)) |-> (r_q.sp == $past(r_q.sp) - ADDR_W'(1)));

    // R2: PC holds at the instruction start while its bytes are fetched
    p_pc_hold_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st inside {S_FETCH_LO, S_ADDR_HI, S_ADDR_LO}) |=> $stable(r_q.pc));

    // R4: flags move only on an execute cycle
    p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != S_EXEC) |=> $stable(r_q.flags));

    // R10: read and write never share a cycle
    p_rw_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
endmodule

// File: tb/tb_byte_cpu_seq.sv
module tb_byte_cpu_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr;
    logic       mem_re;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic [3:0] alu_op;
    logic [7:0] alu_a;
    logic [7:0] alu_b;
    logic [7:0] alu_y;
    logic [3:0] alu_flags;
    logic       halted;

    int n_chk = 0;
    int n_fail = 0;
    int halt_access = 0;
    int rw_both = 0;

    logic [7:0] mem [256];
    logic [7:0] img [256];

    always #10 clk = ~clk;

    byte_cpu_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .alu_op    (alu_op),
        .alu_a     (alu_a),
        .alu_b     (alu_b),
        .alu_y     (alu_y),
        .alu_flags (alu_flags),
        .halted    (halted)
    );

    // ALU model: returns {y, Z, N, C, V}
    function automatic logic [11:0] alu_ref(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [8:0] w;
        logic [7:0] y;
        logic c;
        logic v;
        c = 1'b0;
        v = 1'b0;
        case (op)
            4'h0: begin w = {1'b0, a} + {1'b0, b}; y = w[7:0]; c = w[8];
                        v = (a[7] == b[7]) && (y[7] != a[7]); end
            4'h1, 4'h9: begin y = a - b; c = (a < b);
                        v = (a[7] != b[7]) && (y[7] != a[7]); end
            4'h2: y = a & b;
            4'h3: y = a | b;
            4'h4: y = a ^ b;
            4'h5: begin y = {a[6:0], 1'b0}; c = a[7]; end
            4'h6: begin y = {1'b0, a[7:1]}; c = a[0]; end
            4'h7: y = 8'(a * b);
            4'h8: y = (b == 8'h00) ? 8'hFF : a / b;
            default: y = 8'h00;
        endcase
        return {y, (y == 8'h00), y[7], c, v};
    endfunction

    function automatic logic cond_ref(input logic [3:0] f, input logic [2:0] sel);
        logic base;
        case (sel[2:1])
            2'd0: base = f[3];
            2'd1: base = f[1];
            2'd2: base = f[2];
            default: base = f[0];
        endcase
        return base ^ sel[0];
    endfunction

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [1:0] rd,
                                       input logic [1:0] rs, input logic [7:0] imm);
        return {op, rd, rs, imm};
    endfunction

    always_comb {alu_y, alu_flags} = alu_ref(alu_op, alu_a, alu_b);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            if (mem_re) mem_rdata <= mem[mem_addr];
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (halted && (mem_re || mem_we)) halt_access++;
            if (mem_re && mem_we) rw_both++;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
    endtask

    task automatic put_w(input int at, input logic [15:0] w);
        img[at]     = w[15:8];
        img[at + 1] = w[7:0];
    endtask

    task automatic put_long(input int at, input logic [3:0] op, input logic [1:0] rd,
                            input logic [1:0] rs, input logic [7:0] imm, input logic [15:0] adr);
        put_w(at, enc(op, rd, rs, imm));
        put_w(at + 2, adr);
    endtask

    task automatic run_prog(input bit check_reset, output bit done);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        if (check_reset) begin
            // R1: first cycle reads address 0, no write, not halted
            chk("R1 mem_re", {7'd0, mem_re}, 8'h01);
            chk("R1 mem_addr", mem_addr, 8'h00);
            chk("R1 mem_we", {7'd0, mem_we}, 8'h00);
            chk("R1 halted", {7'd0, halted}, 8'h00);
        end
        done = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (halted) begin
                done = 1'b1;
                break;
            end
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit done;
        logic [7:0] a;
        logic [7:0] b;
        logic [11:0] r;
        logic [1:0] rd;
        logic [1:0] rs;
        logic [3:0] op;
        logic [7:0] pa [3];
        logic [7:0] pb [3];
        void'($urandom(32'd20240611));

        // R3, R5: ALU operations on random register pairs
        for (int t = 0; t < 18; t++) begin
            op = (t < 9) ? 4'(t) : 4'($urandom_range(0, 8));
            a  = 8'($urandom);
            b  = (t == 8) ? 8'h00 : 8'($urandom);
            rd = 2'($urandom);
            rs = rd + 2'($urandom_range(1, 3));
            clear_img();
            img[8'h80] = a;
            img[8'h81] = b;
            put_long(0, 4'hA, rd, 2'd0, 8'h00, 16'h0080);
            put_long(4, 4'hA, rs, 2'd0, 8'h00, 16'h0081);
            put_w(8, enc(op, rd, rs, 8'h00));
            put_long(10, 4'hB, 2'd0, rd, 8'h00, 16'h0090);
            put_long(14, 4'hB, 2'd0, rs, 8'h00, 16'h0091);
            put_w(18, enc(4'hF, 2'd0, 2'd0, 8'h00));
            run_prog(t == 0, done);
            r = alu_ref(op, a, b);
            chk("R9 halt reached", {7'd0, done}, 8'h01);
            chk("R3 alu result in rd", mem[8'h90], r[11:4]);
            chk("R5 rs untouched via store", mem[8'h91], b);
        end

        // R6, R4: compare then conditional jump, taken and untaken
        pa[0] = 8'h00; pb[0] = 8'h00;
        pa[1] = 8'h80; pb[1] = 8'h01;
        pa[2] = 8'h10; pb[2] = 8'h20;
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 4; k++) begin
                if (k < 3) begin a = pa[k]; b = pb[k]; end
                else begin a = 8'($urandom); b = 8'($urandom); end
                clear_img();
                img[8'h80] = a;
                img[8'h81] = b;
                img[8'h82] = 8'h11;
                img[8'h83] = 8'h22;
                put_long(0, 4'hA, 2'd2, 2'd0, 8'h00, 16'h0080);
                put_long(4, 4'hA, 2'd3, 2'd0, 8'h00, 16'h0081);
                put_w(8, enc(4'h9, 2'd2, 2'd3, 8'h00));
                put_long(10, 4'hD, 2'd0, 2'd0, 8'(c), 16'h0020);
                put_long(14, 4'hA, 2'd1, 2'd0, 8'h00, 16'h0083);
                put_long(18, 4'hB, 2'd0, 2'd1, 8'h00, 16'h0090);
                put_long(22, 4'hB, 2'd0, 2'd2, 8'h00, 16'h0091);
                put_w(26, enc(4'hF, 2'd0, 2'd0, 8'h00));
                put_long(8'h20, 4'hA, 2'd1, 2'd0, 8'h00, 16'h0082);
                put_long(8'h24, 4'hB, 2'd0, 2'd1, 8'h00, 16'h0090);
                put_long(8'h28, 4'hB, 2'd0, 2'd2, 8'h00, 16'h0091);
                put_w(8'h2C, enc(4'hF, 2'd0, 2'd0, 8'h00));
                run_prog(1'b0, done);
                r = alu_ref(4'h9, a, b);
                chk("R9 halt reached", {7'd0, done}, 8'h01);
                chk("R6 branch path marker", mem[8'h90],
                    cond_ref(r[3:0], 3'(c)) ? 8'h11 : 8'h22);
                chk("R4 compare keeps rd", mem[8'h91], a);
            end
        end

        // R7, R8, R2: jump and nested calls with nonzero address high bytes
        a = 8'($urandom);
        clear_img();
        img[8'h80] = a;
        put_long(0, 4'hA, 2'd0, 2'd0, 8'h00, 16'hA580);
        put_long(4, 4'hE, 2'd0, 2'd0, 8'h00, 16'hA540);
        put_long(8'h40, 4'hC, 2'd0, 2'd0, 8'h00, 16'h5A50);
        put_w(8'h44, enc(4'hF, 2'd0, 2'd0, 8'h00));
        put_long(8'h50, 4'hE, 2'd0, 2'd0, 8'h00, 16'h0060);
        put_w(8'h54, enc(4'hF, 2'd0, 2'd0, 8'h00));
        put_long(8'h60, 4'hB, 2'd0, 2'd0, 8'h00, 16'h0090);
        put_w(8'h64, enc(4'hF, 2'd0, 2'd0, 8'h00));
        run_prog(1'b0, done);
        chk("R9 halt reached", {7'd0, done}, 8'h01);
        chk("R7 jump reached store", mem[8'h90], a);
        chk("R8 first return addr at SP 0xFE", mem[8'hFE], 8'h08);
        chk("R8 second return addr at SP 0xFD", mem[8'hFD], 8'h54);
        chk("R2 address high byte ignored", mem[8'h80], a);
        chk("R9 no access while halted", 8'(halt_access), 8'h00);
        chk("R10 read and write never together", 8'(rw_both), 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule